// File: doc/BRIEF.md
# Execute-stage ALU with pre-shifted immediates

This block is the execute step of a simple 32-bit integer pipeline for the arithmetic, logic and shift instruction group (opcodes 0 to 18). Each cycle it may receive one instruction word, together with the values already read for its two source registers (called the B and C operands). It decodes the word and computes one result. One clock later it presents that result with the destination register index and a write enable. Opcodes outside the group, and cycles with no valid input, never request a register write.

There are two immediate forms. The short form sign-extends a 17-bit field. The pre-shifted form sign-extends a 10-bit field and then moves it by a 5-bit amount. The move is chosen by a 2-bit mode: shift left, logical right, arithmetic right or rotate right. After the move, the value feeds the add, OR, AND or move operation. The register shift group moves the B operand. Its amount comes either from the instruction or from the low bits of the C operand.

Top module: `exalu_stage`

## Requirements
- R1: The opcode is in instruction bits 31..27 and the destination index in bits 26..22. `wr_idx` shows the destination index of the last valid instruction, one clock after it was accepted.
- R2: `wr_en` is 1 one clock after a valid instruction with opcode 0 to 18. It is 0 after a valid opcode of 19 to 31, and 0 after a cycle without `in_valid`. In a cycle without `in_valid`, `wr_data` and `wr_idx` keep their values.
- R3: For opcodes 0, 2, 4 and 6, let S be bits 16..0 sign-extended. The result is B+S, B|S, B&S and S respectively.
- R4: Opcodes 1, 3, 5 and 7 perform the operations of R3, but with S replaced by bits 16..7 sign-extended and then moved by the amount in bits 4..0. The move is set by bits 6..5: 00 shift left, 01 logical right, 10 arithmetic right, 11 rotate right.
- R5: Opcodes 8 to 14 give, in this order: B+C, B−C, ~C, −C (two's complement), B|C, B&C and B^C.
- R6: Opcodes 15, 16, 17 and 18 give B moved arithmetically right, logically right, left and rotated right. Bit 5 selects the amount: 0 takes bits 4..0 of the instruction, 1 takes the low 5 bits of C. The upper bits of C are ignored.
- R7: The move-immediate opcodes (6, 7) and opcodes 10 and 11 give a result that does not depend on B.
- R8: A move or rotate by an amount of 0 returns its operand unchanged, in both the pre-shifted immediate and the register shift paths.
- R9: While `rst_n` is low at a rising clock edge, `wr_en`, `wr_idx` and `wr_data` become 0 on that edge, whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| rb_val | input | DATA_W | Value of the B source register |
| rc_val | input | DATA_W | Value of the C source register |
| wr_en | output | 1 | Register write request, registered |
| wr_idx | output | 5 | Destination register index, registered |
| wr_data | output | DATA_W | Result, registered |

## Verification
The bench builds the block with the default DATA_W of 32, which is the width the instruction format assumes. At this width every one of the 32 move amounts is reachable from both the immediate field and the C operand. Both sign states of each immediate field and every opcode value from 0 to 31 are also reachable. The bench covers them with directed words and then with a long run of random words, random operands and random idle cycles.

// File: rtl/exalu_pkg.sv
// Shared types for the execute-stage ALU.
// Assumes the fixed 32-bit instruction layout described in the brief.
package exalu_pkg;
    localparam int INSTR_W = 32;
    localparam int IDX_W   = 5;
    localparam int OPC_W   = 5;
    localparam int OPC_LSB = 27;
    localparam int DST_LSB = 22;
    localparam int LAST_ALU_OPC = 18;

    typedef enum logic [1:0] {
        SH_LEFT = 2'b00,
        SH_RLOG = 2'b01,
        SH_RARI = 2'b10,
        SH_ROT  = 2'b11
    } shmode_e;

    typedef enum logic [1:0] {
        OPB_IMM17,
        OPB_IMMSH,
        OPB_RC
    } opb_e;

    typedef enum logic [3:0] {
        FN_ADD, FN_SUB, FN_OR, FN_AND, FN_XOR,
        FN_NOT, FN_NEG, FN_MOVE, FN_SHIFT, FN_NONE
    } fn_e;

    typedef struct packed {
        fn_e     fn;
        opb_e    opb;
        shmode_e rmode;
        logic    amt_from_rc;
        logic    wen;
    } ctrl_t;
endpackage

// File: rtl/exalu_shifter.sv
// Logarithmic shifter/rotator: one stage per bit of the amount.
// Assumes W is a power of two; the amount is taken modulo W.
module exalu_shifter
    import exalu_pkg::*;
#(
    parameter int W = 32
) (
    input  shmode_e                mode,
    input  logic [W-1:0]           val,
    input  logic [$clog2(W)-1:0]   amt,
    output logic [W-1:0]           res
);
    localparam int SH_W = $clog2(W);

    // One fixed-distance move in the selected direction.
    function automatic logic [W-1:0] move_by(shmode_e m, logic [W-1:0] v, int d);
        case (m)
            SH_LEFT: return v << d;
            SH_RLOG: return v >> d;
            SH_RARI: return W'($signed(v) >>> d);
            default: return (v >> d) | (v << (W - d));
        endcase
    endfunction

    logic [W-1:0] stage [SH_W+1];
    assign stage[0] = val;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int DIST = 1 << k;
        // Apply a move of 2**k when amount bit k is set.
        assign stage[k+1] = amt[k] ? move_by(mode, stage[k], DIST) : stage[k];
    end

    assign res = stage[SH_W];

    // Checks that a zero amount passes the operand through and that a rotate keeps every bit.
    always_comb begin
        if (amt == '0)
            AST_ZERO_AMT_PASS: assert (res == val) else $error("zero amount altered value"); // R8
        if (mode == SH_ROT)
            AST_ROT_KEEPS_ONES: assert ($countones(res) == $countones(val)) else $error("rotate lost bits"); // R6
    end
endmodule

// File: rtl/exalu_decode.sv
// Opcode decoder: maps the 5-bit opcode and the shift-source flag to datapath controls.
// Assumes opcodes above LAST_ALU_OPC belong to other units and must not write.
module exalu_decode
    import exalu_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    input  logic             shift_i,
    output ctrl_t            ctrl
);
    // Build the control word for the current opcode.
    always_comb begin
        ctrl.fn          = FN_NONE;
        ctrl.opb         = OPB_RC;
        ctrl.rmode       = SH_LEFT;
        ctrl.amt_from_rc = 1'b0;
        ctrl.wen         = (int'(opc) <= LAST_ALU_OPC);
        if (opc < 5'd8) begin
            ctrl.opb = opc[0] ? OPB_IMMSH : OPB_IMM17;
            case (opc[2:1])
                2'd0:    ctrl.fn = FN_ADD;
                2'd1:    ctrl.fn = FN_OR;
                2'd2:    ctrl.fn = FN_AND;
                default: ctrl.fn = FN_MOVE;
            endcase
        end else begin
            case (opc)
                5'd8:  ctrl.fn = FN_ADD;
                5'd9:  ctrl.fn = FN_SUB;
                5'd10: ctrl.fn = FN_NOT;
                5'd11: ctrl.fn = FN_NEG;
                5'd12: ctrl.fn = FN_OR;
                5'd13: ctrl.fn = FN_AND;
                5'd14: ctrl.fn = FN_XOR;
                5'd15: begin ctrl.fn = FN_SHIFT; ctrl.rmode = SH_RARI; ctrl.amt_from_rc = shift_i; end
                5'd16: begin ctrl.fn = FN_SHIFT; ctrl.rmode = SH_RLOG; ctrl.amt_from_rc = shift_i; end
                5'd17: begin ctrl.fn = FN_SHIFT; ctrl.rmode = SH_LEFT; ctrl.amt_from_rc = shift_i; end
                5'd18: begin ctrl.fn = FN_SHIFT; ctrl.rmode = SH_ROT;  ctrl.amt_from_rc = shift_i; end
                default: ctrl.fn = FN_NONE;
            endcase
        end
    end
endmodule

// File: rtl/exalu_datapath.sv
// Combinational datapath: immediate formation, pre-shift, register shift and function mux.
// Assumes W >= 32 so both immediate fields and the 5-bit amount fit.
module exalu_datapath
    import exalu_pkg::*;
#(
    parameter int W = 32
) (
    input  ctrl_t        ctrl,
    input  logic [16:0]  imm17,
    input  logic [9:0]   imm10,
    input  logic [1:0]   imm_mode,
    input  logic [4:0]   shamt,
    input  logic [W-1:0] rb,
    input  logic [W-1:0] rc,
    output logic [W-1:0] res
);
    localparam int SH_W = $clog2(W);

    logic [W-1:0]    imm17_x, imm10_x, imm_moved, reg_moved, opb;
    logic [SH_W-1:0] reg_amt;

    assign imm17_x = {{(W-17){imm17[16]}}, imm17};
    assign imm10_x = {{(W-10){imm10[9]}}, imm10};
    assign reg_amt = ctrl.amt_from_rc ? rc[SH_W-1:0] : SH_W'(shamt);

    exalu_shifter #(.W(W)) u_imm_sh (
        .mode (shmode_e'(imm_mode)),
        .val  (imm10_x),
        .amt  (SH_W'(shamt)),
        .res  (imm_moved)
    );

    exalu_shifter #(.W(W)) u_reg_sh (
        .mode (ctrl.rmode),
        .val  (rb),
        .amt  (reg_amt),
        .res  (reg_moved)
    );

    // Select the second operand.
    always_comb begin
        case (ctrl.opb)
            OPB_IMM17: opb = imm17_x;
            OPB_IMMSH: opb = imm_moved;
            default:   opb = rc;
        endcase
    end

    // Apply the selected function.
    always_comb begin
        case (ctrl.fn)
            FN_ADD:   res = rb + opb;
            FN_SUB:   res = rb - opb;
            FN_OR:    res = rb | opb;
            FN_AND:   res = rb & opb;
            FN_XOR:   res = rb ^ opb;
            FN_NOT:   res = ~opb;
            FN_NEG:   res = '0 - opb;
            FN_MOVE:  res = opb;
            FN_SHIFT: res = reg_moved;
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/exalu_stage.sv
// Execute stage top: decodes one instruction, computes it and registers the write request.
// Assumes DATA_W is a power of two no smaller than 32; reset is synchronous, active low.
module exalu_stage
    import exalu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  rb_val,
    input  logic [DATA_W-1:0]  rc_val,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [DATA_W-1:0]  wr_data
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] alu_res;
    logic [OPC_W-1:0]  opc;
    logic [9:0]        unused_src_idx;

    assign opc            = instr[OPC_LSB +: OPC_W];
    assign unused_src_idx = instr[21:12];

    exalu_decode u_dec (
        .opc     (opc),
        .shift_i (instr[5]),
        .ctrl    (ctrl)
    );

    exalu_datapath #(.W(DATA_W)) u_dp (
        .ctrl     (ctrl),
        .imm17    (instr[16:0]),
        .imm10    (instr[16:7]),
        .imm_mode (instr[6:5]),
        .shamt    (instr[4:0]),
        .rb       (rb_val),
        .rc       (rc_val),
        .res      (alu_res)
    );

    // Register the write request; hold index and data when no instruction arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= in_valid & ctrl.wen;
            if (in_valid) begin
                wr_idx  <= instr[DST_LSB +: IDX_W];
                wr_data <= alu_res;
            end
        end
    end

    AST_DST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> wr_idx == $past(instr[26:22])); // R1
    AST_NO_WRITE_HIGH_OPC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:27] > 5'd18) |=> !wr_en); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!wr_en && $stable(wr_data) && $stable(wr_idx))); // R2
    AST_WRITE_LOW_OPC: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:27] <= 5'd18) |=> wr_en); // R2
endmodule

// File: tb/sim_exalu_stage.sv
module sim_exalu_stage;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0, rb_val = '0, rc_val = '0;
    logic        wr_en;
    logic [4:0]  wr_idx;
    logic [31:0] wr_data;

    int checks = 0, errors = 0;
    bit done = 0;
    logic        exp_en = 0;
    logic [4:0]  exp_idx = 0;
    logic [31:0] exp_data = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exalu_stage #(.DATA_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .rb_val(rb_val), .rc_val(rc_val),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    // Behavioural move: 0 left, 1 logical right, 2 arithmetic right, 3 rotate right.
    function automatic logic [31:0] mv(int m, logic [31:0] v, int n);
        case (m)
            0: return v << n;
            1: return v >> n;
            2: return $signed(v) >>> n;
            default: return (n == 0) ? v : ((v >> n) | (v << (32 - n)));
        endcase
    endfunction

    // Reference: {write enable, result}.
    function automatic logic [32:0] ref_op(logic [31:0] ins, logic [31:0] b, logic [31:0] c);
        int op = int'(ins[31:27]);
        logic [31:0] s17 = 32'($signed(ins[16:0]));
        logic [31:0] s10 = 32'($signed(ins[16:7]));
        logic [31:0] imm;
        int amt = ins[5] ? int'(c[4:0]) : int'(ins[4:0]);
        if (op < 8) begin
            imm = (op % 2 == 0) ? s17 : mv(int'(ins[6:5]), s10, int'(ins[4:0]));
            case (op / 2)
                0: return {1'b1, b + imm};
                1: return {1'b1, b | imm};
                2: return {1'b1, b & imm};
                default: return {1'b1, imm};
            endcase
        end
        case (op)
            8:  return {1'b1, b + c};
            9:  return {1'b1, b - c};
            10: return {1'b1, ~c};
            11: return {1'b1, 32'd0 - c};
            12: return {1'b1, b | c};
            13: return {1'b1, b & c};
            14: return {1'b1, b ^ c};
            15: return {1'b1, mv(2, b, amt)};
            16: return {1'b1, mv(1, b, amt)};
            17: return {1'b1, mv(0, b, amt)};
            18: return {1'b1, mv(3, b, amt)};
            default: return {1'b0, 32'd0};
        endcase
    endfunction

    function automatic string tag_of(logic [31:0] ins);
        int op = int'(ins[31:27]);
        if (op < 8) return (op % 2 == 0) ? "R3" : "R4";
        if (op < 15) return "R5";
        if (op < 19) return "R6";
        return "R2";
    endfunction

    function automatic logic [31:0] f_i17(int op, int ra, int rb, logic [16:0] imm);
        return {5'(op), 5'(ra), 5'(rb), imm};
    endfunction
    function automatic logic [31:0] f_i10(int op, int ra, logic [9:0] imm, int mode, int sh);
        return {5'(op), 5'(ra), 5'd3, imm, 2'(mode), 5'(sh)};
    endfunction
    function automatic logic [31:0] f_reg(int op, int ra, int sel, int sh);
        return {5'(op), 5'(ra), 5'd1, 5'd2, 6'd0, 1'(sel), 5'(sh)};
    endfunction

    task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Drive one cycle at a falling edge, update the model at the rising edge, compare at the next falling edge.
    task automatic step(logic v, logic [31:0] ins, logic [31:0] b, logic [31:0] c, string tag);
        logic [32:0] r;
        in_valid = v; instr = ins; rb_val = b; rc_val = c;
        @(posedge clk);
        if (!rst_n) begin
            exp_en = 0; exp_idx = 0; exp_data = 0;
        end else if (v) begin
            r = ref_op(ins, b, c);
            exp_en = r[32]; exp_idx = ins[26:22];
            if (r[32] || ins[31:27] > 5'd18) exp_data = r[31:0];
        end else begin
            exp_en = 0;
        end
        @(negedge clk);
        chk("R2", "wr_en", 32'(wr_en), 32'(exp_en));
        chk("R1", "wr_idx", 32'(wr_idx), 32'(exp_idx));
        chk(tag, "wr_data", wr_data, exp_data);
    endtask

    initial begin
        @(negedge clk);
        // R9: reset with a valid instruction present
        rst_n = 0;
        step(1, f_i17(6, 9, 0, 17'h00055), 0, 0, "R9");
        step(1, f_i17(8, 4, 0, 0), 32'h11, 32'h22, "R9");
        rst_n = 1;
        // R3: short immediate, negative and positive
        step(1, f_i17(0, 1, 2, 17'h1FFFF), 32'd100, 0, "R3");
        step(1, f_i17(2, 2, 2, 17'h10F0F), 32'h0000_0001, 0, "R3");
        step(1, f_i17(4, 3, 2, 17'h0FF00), 32'hFFFF_FFFF, 0, "R3");
        step(1, f_i17(6, 4, 2, 17'h10000), 32'h1234_5678, 0, "R3");
        // R4: each pre-shift mode
        step(1, f_i10(1, 5, 10'h3FF, 0, 4), 32'd16, 0, "R4");
        step(1, f_i10(3, 6, 10'h200, 1, 8), 32'h0, 0, "R4");
        step(1, f_i10(5, 7, 10'h200, 2, 8), 32'hFFFF_FFFF, 0, "R4");
        step(1, f_i10(7, 8, 10'h001, 3, 1), 32'h0, 0, "R4");
        step(1, f_i10(7, 8, 10'h155, 3, 31), 32'h0, 0, "R4");
        // R5: register operations in order
        for (int op = 8; op <= 14; op++)
            step(1, f_reg(op, op, 0, 0), 32'h8000_00F0, 32'h0000_0F0F, "R5");
        step(1, f_reg(11, 12, 0, 0), 0, 32'h8000_0000, "R5");
        // R6: shifts with immediate and register amount, upper C bits ignored
        for (int op = 15; op <= 18; op++) begin
            step(1, f_reg(op, 20, 0, 7), 32'h9ABC_DEF1, 32'hFFFF_FFE3, "R6");
            step(1, f_reg(op, 21, 1, 7), 32'h9ABC_DEF1, 32'hFFFF_FFE3, "R6");
            step(1, f_reg(op, 22, 1, 0), 32'h8765_4321, 32'h0000_001F, "R6");
        end
        // R7: results independent of B
        step(1, f_i17(6, 9, 7, 17'h0ABCD), 32'hDEAD_BEEF, 0, "R7");
        step(1, f_i17(6, 9, 7, 17'h0ABCD), 32'h0123_4567, 0, "R7");
        step(1, f_i10(7, 9, 10'h2AA, 2, 3), 32'hFFFF_0000, 0, "R7");
        step(1, f_reg(10, 9, 0, 0), 32'hFFFF_FFFF, 32'h0F0F_0F0F, "R7");
        step(1, f_reg(11, 9, 0, 0), 32'h5555_5555, 32'h0000_0003, "R7");
        // R8: zero amounts
        for (int m = 0; m < 4; m++)
            step(1, f_i10(1, 10, 10'h2F1, m, 0), 32'h1, 0, "R8");
        for (int op = 15; op <= 18; op++) begin
            step(1, f_reg(op, 11, 0, 0), 32'hC001_D00D, 0, "R8");
            step(1, f_reg(op, 11, 1, 5), 32'hC001_D00D, 32'hFFFF_FFE0, "R8");
        end
        // R2: non-ALU opcodes and idle cycles holding state
        step(1, f_i17(4, 13, 0, 17'h1FFFF), 32'h7777_7777, 0, "R2");
        step(0, f_i17(8, 14, 0, 0), 32'h1, 32'h2, "R2");
        step(0, 32'hFFFF_FFFF, 32'h3, 32'h4, "R2");
        for (int op = 19; op <= 31; op++)
            step(1, {5'(op), 5'(op), 22'h2A5A5}, 32'h1, 32'h2, "R2");
        // Random run with idle cycles and a mid-run reset
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] w = $urandom;
            logic v = ($urandom % 5) != 0;
            if (n == 1500) rst_n = 0;
            if (n == 1502) rst_n = 1;
            step(v, w, $urandom, $urandom, rst_n ? tag_of(w) : "R9");
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R2 got hung expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule